// File: doc/BRIEF.md
# CAN Mailbox Receive-Pending Flag Register

This block keeps one pending flag per receive mailbox of a CAN controller, 16 in all. A receive engine sends a single-cycle completion strobe that names the mailbox and says whether the stored frame was a data frame or a remote frame. A per-mailbox configuration vector says which mailboxes may receive data frames. A flag is set only when a data frame lands in a mailbox configured for data-frame reception. Remote frames never set a flag, and neither does a report for a mailbox configured otherwise.

Software reads all 16 flags at once through a simple register bus. It clears flags by writing ones. A zero in the write word leaves that flag as it is, and a write can never set a flag. If a reception and a software clear hit the same bit in the same cycle, the reception wins, so no frame is lost.

The pending flags feed a data-frame-received interrupt flag, which is gated by a per-mailbox mask vector. That flag drives a registered interrupt output, which is gated by a global mask. The completion strobe carries no back-pressure. The block accepts a report in every cycle, so the engine never waits and needs no ready signal. All other pins are plain control and status.

Top module: `can_rx_pend_flags`

## Requirements
- R1: After reset, all 16 flags, the interrupt flag and the interrupt output are 0.
- R2: A strobe with `rx_is_data`=1, mailbox index n (0..15) and `rx_cfg[n]`=1 sets flag n, read back as bit n of `rd_flags` right after the clock edge that samples the strobe.
- R3: A strobe with `rx_is_data`=0 (remote frame) sets no flag.
- R4: A strobe for mailbox n while `rx_cfg[n]`=0 sets no flag.
- R5: A write with `wr_en`=1 clears every flag whose bit in `wr_data` is 1. It leaves flags whose bit is 0 unchanged and never sets a flag.
- R6: When a set event and a write-1 clear target the same flag in the same cycle, the flag ends up set.
- R7: `dfrx_flag` is the OR over n of (flag n AND NOT `irq_mask[n]`). It falls by itself once every unmasked flag is cleared.
- R8: `irq_out` equals, one clock later, `dfrx_flag` AND NOT `glob_mask`.
- R9: `rd_flags` shows the current flags with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_done | input | 1 | Single-cycle reception-complete strobe |
| rx_mbox | input | 4 | Mailbox index of the stored frame |
| rx_is_data | input | 1 | 1 = data frame, 0 = remote frame |
| rx_cfg | input | 16 | Bit n = 1 if mailbox n receives data frames |
| irq_mask | input | 16 | Bit n = 1 masks mailbox n from the interrupt flag |
| glob_mask | input | 1 | 1 masks the interrupt output |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write-one-to-clear word |
| rd_flags | output | 16 | Current pending flags |
| dfrx_flag | output | 1 | Data-frame-received interrupt flag |
| irq_out | output | 1 | Registered interrupt output |

## Verification
A flag cell in the wrong state shows on `rd_flags` in the very cycle after the edge that should have set or cleared it. A wrong flag also shows on `dfrx_flag` at once and on `irq_out` one clock later. The bench therefore compares all three outputs after every clock edge against a model queue. An extra set caused by a remote frame or an unconfigured mailbox, or a clear that wins over a set, appears within a single cycle. A masking error appears only as a wrong level on the two interrupt outputs.

// File: rtl/can_rxp_pkg.sv
package can_rxp_pkg;
  localparam int unsigned MBOX_N = 16;
endpackage

// File: rtl/rxp_set_decode.sv
module rxp_set_decode #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_done,
  input  logic [IDX_W-1:0] rx_mbox,
  input  logic             rx_is_data,
  input  logic [N-1:0]     rx_cfg,
  output logic [N-1:0]     set_vec
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      set_vec[i] = rx_done && rx_is_data && rx_cfg[i] && (rx_mbox == IDX_W'(i));
    end
  end

  // R2
  set_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(set_vec));
endmodule

// File: rtl/rxp_flag_cell.sv
module rxp_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> q);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !set_i) |=> !q);
  // R5
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (!set_i && !q) |=> !q);
endmodule

// File: rtl/rxp_irq_gen.sv
module rxp_irq_gen #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] irq_mask,
  input  logic         glob_mask,
  output logic         dfrx_flag,
  output logic         irq_out
);
  assign dfrx_flag = |(flags & ~irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= dfrx_flag & ~glob_mask;
  end

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) (dfrx_flag && !glob_mask) |=> irq_out);
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !(dfrx_flag && !glob_mask) |=> !irq_out);
endmodule

// File: rtl/can_rx_pend_flags.sv
module can_rx_pend_flags #(
  parameter int unsigned N_MBOX = can_rxp_pkg::MBOX_N,
  localparam int unsigned IDX_W = $clog2(N_MBOX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [IDX_W-1:0]  rx_mbox,
  input  logic              rx_is_data,
  input  logic [N_MBOX-1:0] rx_cfg,
  input  logic [N_MBOX-1:0] irq_mask,
  input  logic              glob_mask,
  input  logic              wr_en,
  input  logic [N_MBOX-1:0] wr_data,
  output logic [N_MBOX-1:0] rd_flags,
  output logic              dfrx_flag,
  output logic              irq_out
);
  logic [N_MBOX-1:0] set_vec;
  logic [N_MBOX-1:0] clr_vec;
  logic [N_MBOX-1:0] flags;

  rxp_set_decode #(.N(N_MBOX), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_mbox(rx_mbox),
    .rx_is_data(rx_is_data), .rx_cfg(rx_cfg), .set_vec(set_vec)
  );

  assign clr_vec = wr_en ? wr_data : '0;

  for (genvar g = 0; g < N_MBOX; g++) begin : g_cell
    rxp_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec[g]), .clr_i(clr_vec[g]), .q(flags[g])
    );
  end

  rxp_irq_gen #(.N(N_MBOX)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flags), .irq_mask(irq_mask),
    .glob_mask(glob_mask), .dfrx_flag(dfrx_flag), .irq_out(irq_out)
  );

  // R9
  assign rd_flags = flags;

  // R3
  remote_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_is_data) |=> ((rd_flags & ~$past(rd_flags)) == '0));
  // R4
  unconfigured_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_cfg[rx_mbox]) |=> ((rd_flags & ~$past(rd_flags)) == '0));
  // R2
  data_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_is_data && rx_cfg[rx_mbox]) |=> (rd_flags[$past(rx_mbox)]));
endmodule

// File: tb/can_rx_pend_flags_test.sv
module can_rx_pend_flags_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 1'b0, rx_is_data = 1'b0, glob_mask = 1'b0, wr_en = 1'b0;
  logic [3:0] rx_mbox = '0;
  logic [15:0] rx_cfg = '0, irq_mask = '0, wr_data = '0;
  logic [15:0] rd_flags;
  logic dfrx_flag, irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_pend_flags uut (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_mbox(rx_mbox),
    .rx_is_data(rx_is_data), .rx_cfg(rx_cfg), .irq_mask(irq_mask),
    .glob_mask(glob_mask), .wr_en(wr_en), .wr_data(wr_data),
    .rd_flags(rd_flags), .dfrx_flag(dfrx_flag), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [15:0] flags;
    logic        dfrx;
    logic        irq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  logic [15:0] m_flags = '0;
  logic        done = 1'b0;

  task automatic drive(input logic dn, input logic [3:0] idx, input logic isd,
                       input logic we, input logic [15:0] wd,
                       input logic [15:0] cfg, input logic [15:0] im,
                       input logic gm, input string tag);
    exp_t e;
    logic [15:0] setv, clrv;
    @(negedge clk);
    rx_done = dn; rx_mbox = idx; rx_is_data = isd;
    wr_en = we; wr_data = wd; rx_cfg = cfg; irq_mask = im; glob_mask = gm;
    e.irq = (|(m_flags & ~im)) & ~gm;
    setv = (dn && isd && cfg[idx]) ? (16'h1 << idx) : 16'h0;
    clrv = we ? wd : 16'h0;
    m_flags = (m_flags & ~clrv) | setv;
    e.flags = m_flags;
    e.dfrx = |(m_flags & ~im);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rd_flags !== e.flags || dfrx_flag !== e.dfrx || irq_out !== e.irq) begin
        n_fail++;
        $display("FAIL %s: flags=%h dfrx=%b irq=%b expected flags=%h dfrx=%b irq=%b",
                 t, rd_flags, dfrx_flag, irq_out, e.flags, e.dfrx, e.irq);
      end
    end
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion", wd_cnt);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R1");
    // R2 data frame sets flag 3, R9 read immediately
    drive(1, 3, 1, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R2");
    // R8 irq_out one cycle later
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R8");
    // R3 remote frame ignored
    drive(1, 5, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R3");
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R3");
    // R4 unconfigured mailbox ignored
    drive(1, 7, 1, 0, 16'h0, 16'hFF7F, 16'h0, 0, "R4");
    drive(0, 0, 0, 0, 16'h0, 16'hFF7F, 16'h0, 0, "R4");
    // R5 write zero no effect, write ones to clear bits no set
    drive(0, 0, 0, 1, 16'h0000, 16'hFFFF, 16'h0, 0, "R5");
    drive(0, 0, 0, 1, 16'hFFF7, 16'hFFFF, 16'h0, 0, "R5");
    drive(0, 0, 0, 1, 16'h0008, 16'hFFFF, 16'h0, 0, "R5");
    // R7 dfrx drops after clear, R8 irq follows
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R7");
    // R2 boundaries 0 and 15
    drive(1, 0, 1, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R2");
    drive(1, 15, 1, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R2");
    // R6 set and clear same bit same cycle
    drive(1, 15, 1, 1, 16'h8001, 16'hFFFF, 16'h0, 0, "R6");
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R6");
    // R7 per-mailbox mask hides flag 15
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h8000, 0, "R7");
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h8000, 0, "R7");
    // R8 global mask blocks irq_out, then unmask
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 1, "R8");
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 1, "R8");
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R8");
    drive(0, 0, 0, 1, 16'hFFFF, 16'hFFFF, 16'h0, 0, "R5");
    // R2 every mailbox, alternating configuration and type
    for (int i = 0; i < 16; i++) begin
      drive(1, 4'(i), 1, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R2");
      drive(1, 4'(i), 0, 0, 16'h0, 16'h0, 16'h0, 0, "R3");
    end
    drive(0, 0, 0, 1, 16'hA5A5, 16'hFFFF, 16'h5A5A, 0, "R7");
    drive(0, 0, 0, 1, 16'h5A5A, 16'hFFFF, 16'h5A5A, 0, "R7");
    drive(0, 0, 0, 0, 16'h0, 16'hFFFF, 16'h0, 0, "R8");
    repeat (2) @(posedge clk);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule